// File: doc/BRIEF.md
# Per-Thread Run and Restart Controller

This block starts and halts the hardware threads (virtual processors, VPs) of one core from software. Software reaches it through a small register port. Writing a mask to the start register brings VPs into the running state. Writing a mask to the halt register suspends them. A read-only status register reports which VPs are running. Starting a VP never simply resumes it. The block gives the VP a one-cycle restart pulse, and in the same cycle it presents the address from which that VP must fetch after restart.

Each VP owns a restart-base register and a redirect register, and both sit in a local window keyed by the VP that issues the access (`reqVp`). The restart-base register holds the address used at the VP's next restart. The redirect register names a target VP. A second window then reaches the target's restart base, so code on one VP can set up another VP before starting it. A build parameter chooses whether only VP0 runs when system reset is released or all VPs do. A combined start/halt register lets one write carry both masks, and the halt mask wins for any VP named in both.

Top module: `vp_run_ctl`

## Requirements
- R1: With `FIRST_ONLY`=1, after reset `vpRunEn` is 0001 and `vpRstPulse` is 0. Every restart base and every `vpRstAddr` slice equals `RESET_BASE`, and every redirect register is 0.
- R2: A write to register 0 (start) with bit i = 1 makes `vpRunEn[i]` = 1 and `vpRstPulse[i]` = 1 from the next clock edge. The pulse lasts exactly one cycle.
- R3: A write to register 1 (halt) with bit i = 1 makes `vpRunEn[i]` = 0 from the next edge, with no pulse.
- R4: Zero bits in a start or halt mask leave the matching VP's run state unchanged and produce no pulse.
- R5: A read of register 2 returns `vpRunEn` in bits [NUM_VP-1:0] and zero above them. A write to register 2 changes nothing. Reads of registers 0, 1 and 6 return 0.
- R6: A start write to a VP that is already running issues a new one-cycle restart pulse, and the VP stays running.
- R7: In the cycle `vpRstPulse[i]` is 1, slice i of `vpRstAddr` carries VP i's restart base as it stood before the start write. At all other times the slice holds its value.
- R8: Register 4 (local restart base) reads and writes the restart base of VP `reqVp`.
- R9: Register 3 holds the redirect target of VP `reqVp` and reads back from it. Register 5 reads and writes the restart base of the VP named by the requester's redirect register.
- R10: Register 6 carries the start mask in bits [NUM_VP-1:0] and the halt mask in bits [2*NUM_VP-1:NUM_VP]. A VP named in both masks is halted and gets no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the register port |
| reqVp | input | VPW | VP issuing the access |
| regAddr | input | 3 | Register index |
| wdata | input | XLEN | Write data |
| rdata | output | XLEN | Read data, combinational from regAddr and reqVp |
| vpRunEn | output | NUM_VP | Run enable per VP |
| vpRstPulse | output | NUM_VP | One-cycle restart pulse per VP |
| vpRstAddr | output | NUM_VP*XLEN | Restart address per VP, slice i for VP i |

## Verification
The start and halt effects, the restart pulses and the restart addresses all come from registers. Each is due at the clock edge that captures the write. The bench drives a write at a falling edge and samples at the following falling edge, so it sees exactly that first cycle. It samples once more one cycle later to confirm the pulse has dropped. Read data is combinational, so the bench checks it 1 ns after it sets the address, with no edge in between.

// File: rtl/vprun_pkg.sv
package vprun_pkg;

  // Register indices; the decode in vprun_ctl depends on these values.
  typedef enum logic [2:0] {
    REG_START   = 3'd0,
    REG_HALT    = 3'd1,
    REG_STATUS  = 3'd2,
    REG_REDIR   = 3'd3,
    REG_BASELOC = 3'd4,
    REG_BASEOTH = 3'd5,
    REG_PAIR    = 3'd6
  } regsel_t;

  // Strobes from the decoder to the state-holding datapath.
  typedef struct packed {
    logic startWr;
    logic haltWr;
    logic pairWr;
    logic baseWr;
    logic redirWr;
  } strobe_t;

endpackage

// File: rtl/vprun_ctl.sv
module vprun_ctl
  import vprun_pkg::*;
#(
  parameter int VPW = 2
) (
  input  logic           wrEn,
  input  logic [2:0]     regAddr,
  input  logic [VPW-1:0] reqVp,
  input  logic [VPW-1:0] redirOf,
  output strobe_t        stb,
  output logic [VPW-1:0] baseIdx,
  output regsel_t        rdSel
);

  regsel_t sel;
  assign sel   = regsel_t'(regAddr);
  assign rdSel = sel;

  always_comb begin
    stb     = '0;
    baseIdx = reqVp;
    if (sel == REG_BASEOTH) baseIdx = redirOf;
    if (wrEn) begin
      case (sel)
        REG_START:   stb.startWr = 1'b1;
        REG_HALT:    stb.haltWr  = 1'b1;
        REG_PAIR:    stb.pairWr  = 1'b1;
        REG_REDIR:   stb.redirWr = 1'b1;
        REG_BASELOC,
        REG_BASEOTH: stb.baseWr  = 1'b1;
        default:     stb         = '0;
      endcase
    end
  end

endmodule

// File: rtl/vprun_dp.sv
module vprun_dp
  import vprun_pkg::*;
#(
  parameter int          NUM_VP     = 4,
  parameter int          XLEN       = 32,
  parameter int          VPW        = 2,
  parameter logic [XLEN-1:0] RESET_BASE = 32'h1FC0_0000,
  parameter bit          FIRST_ONLY = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                stb,
  input  regsel_t                rdSel,
  input  logic [XLEN-1:0]        wdata,
  input  logic [VPW-1:0]         reqVp,
  input  logic [VPW-1:0]         baseIdx,
  output logic [VPW-1:0]         redirOf,
  output logic [XLEN-1:0]        rdata,
  output logic [NUM_VP-1:0]      vpRunEn,
  output logic [NUM_VP-1:0]      vpRstPulse,
  output logic [NUM_VP*XLEN-1:0] vpRstAddr
);

  localparam logic [NUM_VP-1:0] RUN_INIT =
    FIRST_ONLY ? NUM_VP'(1) : {NUM_VP{1'b1}};

  logic [XLEN-1:0]   baseReg  [NUM_VP];
  logic [XLEN-1:0]   addrReg  [NUM_VP];
  logic [VPW-1:0]    redirReg [NUM_VP];
  logic [NUM_VP-1:0] startMask, haltMask, goMask;

  always_comb begin
    startMask = '0;
    haltMask  = '0;
    if (stb.startWr) startMask = wdata[NUM_VP-1:0];
    if (stb.haltWr)  haltMask  = wdata[NUM_VP-1:0];
    if (stb.pairWr) begin
      startMask = wdata[NUM_VP-1:0];
      haltMask  = wdata[2*NUM_VP-1:NUM_VP];
    end
    goMask = startMask & ~haltMask;   // halt wins
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpRunEn    <= RUN_INIT;
      vpRstPulse <= '0;
    end else begin
      vpRunEn    <= (vpRunEn & ~haltMask) | goMask;
      vpRstPulse <= goMask;
    end
  end

  assign redirOf = redirReg[reqVp];

  for (genvar i = 0; i < NUM_VP; i++) begin : g_vp
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseReg[i]  <= RESET_BASE;
        addrReg[i]  <= RESET_BASE;
        redirReg[i] <= '0;
      end else begin
        if (stb.baseWr && baseIdx == VPW'(i)) baseReg[i] <= wdata;
        if (stb.redirWr && reqVp == VPW'(i))  redirReg[i] <= wdata[VPW-1:0];
        if (goMask[i])                        addrReg[i] <= baseReg[i];
      end
    end
    assign vpRstAddr[i*XLEN +: XLEN] = addrReg[i];

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
      goMask[i] |=> (vpRstPulse[i] && vpRunEn[i]));
    // R3
    halt_state_chk: assert property (@(posedge clk) disable iff (!rstN)
      haltMask[i] |=> (!vpRunEn[i] && !vpRstPulse[i]));
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(startMask[i] || haltMask[i]) |=> ($stable(vpRunEn[i]) && !vpRstPulse[i]));
    // R7
    pulse_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
      vpRstPulse[i] |-> (vpRstAddr[i*XLEN +: XLEN] == $past(baseReg[i])));
    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !vpRstPulse[i] |-> $stable(vpRstAddr[i*XLEN +: XLEN]));
  end

  always_comb begin
    rdata = '0;
    case (rdSel)
      REG_STATUS:  rdata[NUM_VP-1:0] = vpRunEn;
      REG_REDIR:   rdata[VPW-1:0]    = redirReg[reqVp];
      REG_BASELOC: rdata             = baseReg[reqVp];
      REG_BASEOTH: rdata             = baseReg[redirOf];
      default:     rdata             = '0;
    endcase
  end

  // R10
  pulse_vs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vpRstPulse & ~vpRunEn) == '0);

endmodule

// File: rtl/vp_run_ctl.sv
module vp_run_ctl
  import vprun_pkg::*;
#(
  parameter int              NUM_VP     = 4,
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] RESET_BASE = 32'h1FC0_0000,
  parameter bit              FIRST_ONLY = 1'b1,
  localparam int             VPW        = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [VPW-1:0]         reqVp,
  input  logic [2:0]             regAddr,
  input  logic [XLEN-1:0]        wdata,
  output logic [XLEN-1:0]        rdata,
  output logic [NUM_VP-1:0]      vpRunEn,
  output logic [NUM_VP-1:0]      vpRstPulse,
  output logic [NUM_VP*XLEN-1:0] vpRstAddr
);

  strobe_t        stb;
  regsel_t        rdSel;
  logic [VPW-1:0] baseIdx, redirOf;

  vprun_ctl #(.VPW(VPW)) u_ctl (
    .wrEn(wrEn), .regAddr(regAddr), .reqVp(reqVp), .redirOf(redirOf),
    .stb(stb), .baseIdx(baseIdx), .rdSel(rdSel)
  );

  vprun_dp #(
    .NUM_VP(NUM_VP), .XLEN(XLEN), .VPW(VPW),
    .RESET_BASE(RESET_BASE), .FIRST_ONLY(FIRST_ONLY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .wdata(wdata),
    .reqVp(reqVp), .baseIdx(baseIdx), .redirOf(redirOf), .rdata(rdata),
    .vpRunEn(vpRunEn), .vpRstPulse(vpRstPulse), .vpRstAddr(vpRstAddr)
  );

endmodule

// File: tb/sim_vp_run_ctl.sv
module sim_vp_run_ctl;
  localparam int N = 4;
  localparam int X = 32;
  localparam logic [31:0] DEF = 32'h1FC0_0000;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [1:0] reqVp = '0;
  logic [2:0] regAddr = '0;
  logic [X-1:0] wdata = '0, rdata;
  logic [N-1:0] vpRunEn, vpRstPulse;
  logic [N*X-1:0] vpRstAddr;

  int vectors = 0, miscompares = 0;
  logic [X-1:0] expBase [N];
  logic [X-1:0] expAddr [N];

  always #5 clk = ~clk;

  vp_run_ctl #(.NUM_VP(N), .XLEN(X), .RESET_BASE(DEF), .FIRST_ONLY(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .reqVp(reqVp), .regAddr(regAddr),
    .wdata(wdata), .rdata(rdata), .vpRunEn(vpRunEn), .vpRstPulse(vpRstPulse),
    .vpRstAddr(vpRstAddr)
  );

  task automatic chk(input string req, input logic [X-1:0] act, input logic [X-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int vp, input int a, input logic [X-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; reqVp = 2'(vp); regAddr = 3'(a); wdata = d;
    @(negedge clk);
    wrEn = 1'b0; wdata = '0;
  endtask

  task automatic rd(input int vp, input int a, output logic [X-1:0] d);
    @(negedge clk);
    wrEn = 1'b0; reqVp = 2'(vp); regAddr = 3'(a);
    #1 d = rdata;
  endtask

  task automatic chkAddrs(input string req);
    for (int v = 0; v < N; v++) chk(req, vpRstAddr[v*X +: X], expAddr[v]);
  endtask

  initial begin
    logic [X-1:0] d;
    logic [N-1:0] expRun, go;
    for (int v = 0; v < N; v++) begin expBase[v] = DEF; expAddr[v] = DEF; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 run", X'(vpRunEn), 32'h1);
    chk("R1 pulse", X'(vpRstPulse), 32'h0);
    chkAddrs("R1 addr");
    for (int v = 0; v < N; v++) begin
      rd(v, 4, d); chk("R1 base", d, DEF);
      rd(v, 3, d); chk("R1 redir", d, 0);
    end
    // R5 status and write-only reads
    rd(0, 2, d); chk("R5 status", d, 32'h1);
    rd(0, 0, d); chk("R5 start reads 0", d, 0);
    rd(0, 1, d); chk("R5 halt reads 0", d, 0);
    rd(0, 6, d); chk("R5 pair reads 0", d, 0);

    // R2/R3/R7/R8 sweep over every start mask
    for (int m = 0; m < 16; m++) begin
      wr(m % N, 1, 32'hF);
      chk("R3 halted", X'(vpRunEn), 0);
      chk("R3 no pulse", X'(vpRstPulse), 0);
      for (int v = 0; v < N; v++) begin
        expBase[v] = 32'h2000_0000 + (m << 8) + (v << 4);
        wr(v, 4, expBase[v]);
      end
      for (int v = 0; v < N; v++) begin rd((v + 1) % N, 4, d); chk("R8 base", d, expBase[(v + 1) % N]); end
      wr(0, 0, X'(m));
      chk("R2 run", X'(vpRunEn), X'(m));
      chk("R2 pulse", X'(vpRstPulse), X'(m));
      for (int v = 0; v < N; v++) if (m[v]) expAddr[v] = expBase[v];
      chkAddrs("R7 addr");
      @(negedge clk);
      chk("R2 pulse width", X'(vpRstPulse), 0);
      chk("R4 run held", X'(vpRunEn), X'(m));
      chkAddrs("R7 hold");
      rd(2, 2, d); chk("R5 status", d, X'(m));
    end
    // now all four running
    wr(1, 4, 32'h3000_0040); expBase[1] = 32'h3000_0040;
    wr(0, 0, 32'h2);
    chk("R6 rerun pulse", X'(vpRstPulse), 32'h2);
    chk("R6 still run", X'(vpRunEn), 32'hF);
    expAddr[1] = expBase[1];
    chkAddrs("R6 addr");
    wr(0, 0, 32'h0);
    chk("R4 zero start", X'(vpRunEn), 32'hF);
    chk("R4 zero start pulse", X'(vpRstPulse), 0);
    wr(0, 1, 32'h0);
    chk("R4 zero halt", X'(vpRunEn), 32'hF);
    wr(0, 2, 32'h0);
    rd(0, 2, d); chk("R5 status write ignored", d, 32'hF);
    chk("R5 status run", X'(vpRunEn), 32'hF);

    // R9 redirect window
    wr(1, 3, 32'h3);
    rd(1, 3, d); chk("R9 redir readback", d, 32'h3);
    rd(0, 3, d); chk("R9 redir per vp", d, 32'h0);
    wr(1, 5, 32'h4444_0000); expBase[3] = 32'h4444_0000;
    rd(3, 4, d); chk("R9 target base", d, expBase[3]);
    rd(1, 4, d); chk("R9 own base kept", d, expBase[1]);
    rd(1, 5, d); chk("R9 window read", d, expBase[3]);
    wr(2, 0, 32'h8);
    expAddr[3] = expBase[3];
    chk("R9 pulse", X'(vpRstPulse), 32'h8);
    chkAddrs("R9 addr");

    // R10 combined register, all start/halt pairs
    for (int r = 0; r < 16; r++) begin
      for (int s = 0; s < 16; s++) begin
        wr(0, 1, 32'hF);
        wr(0, 0, 32'h5);
        wr(0, 6, X'((s << N) | r));
        go = 4'(r) & ~4'(s);
        expRun = (4'h5 & ~4'(s)) | go;
        chk("R10 run", X'(vpRunEn), X'(expRun));
        chk("R10 pulse", X'(vpRstPulse), X'(go));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule